// File: doc/BRIEF.md
# Real-Time Periodic Interrupt Generator

This block raises a periodic interrupt flag from the bus clock. A 16-bit divider counts bus cycles from reset and never reloads. A tick fires when the low-order part of the divider wraps to zero. Software picks the size of that part, from 13 to 16 bits, with a 2-bit rate field. Each tick sets a sticky flag, and the flag stays set until software clears it through the register write port.

The same control register also holds a 2-bit prescaler field that is protected against stray writes. In normal mode the field takes one write, and only within the first 64 bus cycles after reset. After that it is frozen until the next reset. In special mode the field takes every write.

Register map: `wr_addr` 0 selects the control register and 1 selects the flag register. In the control register, bits 1:0 hold the rate and bits 3:2 hold the prescaler.

Top module: `rti_gen`

## Requirements
- R1: After reset, `irq_flag` is 0, `rate_sel` is 00 and `presc_sel` is 00.
- R2: With rate 00, the flag first sets on the 8192nd rising clock edge after reset is released, and then at every multiple of 8192 edges.
- R3: Rate 01 sets the flag at multiples of 16384 edges after reset, rate 10 at multiples of 32768 edges, and rate 11 at multiples of 65536 edges.
- R4: Once set, the flag holds until a write to address 1 with data bit 0 equal to 1, which clears it on that edge. A write to address 1 with bit 0 equal to 0 leaves the flag unchanged.
- R5: When a clear write and a tick fall on the same edge, the flag is set after that edge.
- R6: A change of rate does not reset the divider. The next tick comes at the next multiple of the new period, counted from reset.
- R7: In normal mode (`special_mode` = 0), the first control write landing on edges 1 to 64 after reset loads the prescaler from bits 3:2. Edge 64 is included.
- R8: In normal mode, a prescaler write is ignored, leaving `presc_sel` unchanged, in two cases: after one write has been accepted, or when the write lands on edge 65 or later.
- R9: In special mode, every control write loads the prescaler, at any time after reset.
- R10: Every control write loads the rate from bits 1:0, whatever the mode or lock state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | 1 lets the prescaler be rewritten at any time |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the control register, 1 selects the flag register |
| wr_data | input | 8 | Write data |
| rate_sel | output | 2 | Current rate field |
| presc_sel | output | 2 | Current prescaler field |
| irq_flag | output | 1 | Sticky periodic interrupt flag |

## Verification
The hardest situations to reach from the ports are the exact edges of the 64-cycle window and a clear that lands on the same edge as a tick. The bench keeps its own edge counter from reset release. It places one write on edge 64 and, after a separate reset, another on edge 65. It also times a clear write to land on the edge where the divider wraps, and changes the rate in the middle of a period to show that the tick stays locked to multiples of the new period.

// File: rtl/rti_pkg.sv
`timescale 1ns/1ps
package rti_pkg;

  // Register selector carried on wr_addr.
  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_FLAG = 1'b1
  } rti_reg_e;

  // Number of divider bits that must wrap for a given rate code.
  function automatic int unsigned period_shift(int unsigned base, int unsigned code);
    return base + code;
  endfunction

  // Period in bus cycles for a rate code.
  function automatic longint unsigned period_cycles(int unsigned base, int unsigned code);
    return longint'(1) << period_shift(base, code);
  endfunction

endpackage

// File: rtl/rti_divider.sv
`timescale 1ns/1ps
module rti_divider #(
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned RATE_BASE = 13,
  parameter int unsigned RATE_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int unsigned NUM_RATES = 1 << RATE_W;

  logic [DIV_W-1:0]     cnt;
  logic [NUM_RATES-1:0] wrap_vec;

  // Free-running count; never reloaded by a rate change.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  // One wrap detector per rate: all low bits at ones means the next edge wraps.
  for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
    localparam int unsigned SH = rti_pkg::period_shift(RATE_BASE, g);
    assign wrap_vec[g] = &cnt[SH-1:0];
  end

  assign tick = wrap_vec[rate];

  // R6: a tick is always followed by the shortest-period bits at zero.
  a_r6_tick_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt[RATE_BASE-1:0] == '0));

  // R2: no tick unless the shortest-period field is about to wrap.
  a_r2_tick_needs_base_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (&cnt[RATE_BASE-1:0]));

endmodule

// File: rtl/rti_ctrl_reg.sv
`timescale 1ns/1ps
module rti_ctrl_reg #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned RATE_W     = 2,
  parameter int unsigned PRESC_W    = 2,
  parameter int unsigned RATE_LSB   = 0,
  parameter int unsigned PRESC_LSB  = 2,
  parameter int unsigned WIN_CYCLES = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               special_mode,
  input  logic               wr_ctrl,
  input  logic [DATA_W-1:0]  wdata,
  output logic [RATE_W-1:0]  rate,
  output logic [PRESC_W-1:0] presc
);
  localparam int unsigned      WIN_W   = $clog2(WIN_CYCLES + 1);
  localparam logic [WIN_W-1:0] WIN_END = WIN_W'(WIN_CYCLES);

  logic [WIN_W-1:0] win_cnt;
  logic             win_open;
  logic             locked;
  logic             presc_wr_ok;
  logic             presc_lock_evt;
  logic             wdata_unused;

  assign wdata_unused = ^wdata;

  // Saturating count of edges since reset; the window closes at WIN_CYCLES.
  assign win_open = (win_cnt != WIN_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        win_cnt <= '0;
    else if (win_open) win_cnt <= win_cnt + 1'b1;
  end

  // Normal mode: one write inside the window; special mode: always.
  assign presc_lock_evt = wr_ctrl && !special_mode && win_open && !locked;
  assign presc_wr_ok    = wr_ctrl && (special_mode || (win_open && !locked));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locked <= 1'b0;
    else        locked <= locked | presc_lock_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       presc <= '0;
    else if (presc_wr_ok) presc <= wdata[PRESC_LSB +: PRESC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rate <= '0;
    else if (wr_ctrl) rate <= wdata[RATE_LSB +: RATE_W];
  end

  // R8: in normal mode a locked or expired field never moves.
  a_r8_presc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!special_mode && (locked || !win_open)) |=> $stable(presc));

  // R7: the one-shot lock never releases before reset.
  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R7: a normal-mode write inside an unused window closes the one-shot.
  a_r7_write_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !special_mode && win_open) |=> locked);

  // R9: special mode always loads the prescaler.
  a_r9_special_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && special_mode) |=> (presc == $past(wdata[PRESC_LSB +: PRESC_W])));

  // R10: the rate field loads on every control write.
  a_r10_rate_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (rate == $past(wdata[RATE_LSB +: RATE_W])));

endmodule

// File: rtl/rti_flag.sv
`timescale 1ns/1ps
module rti_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr_req,
  output logic flag
);
  // Set has priority so a tick is never lost to a concurrent clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (tick)    flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  // R5: a tick sets the flag even against a clear.
  a_r5_tick_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> flag);

  // R4: a clear without a tick drops the flag.
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !tick) |=> !flag);

  // R4: no tick and no clear, the flag holds.
  a_r4_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr_req) |=> $stable(flag));

endmodule

// File: rtl/rti_gen.sv
`timescale 1ns/1ps
module rti_gen #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned DIV_W      = 16,
  parameter int unsigned RATE_BASE  = 13,
  parameter int unsigned RATE_W     = 2,
  parameter int unsigned PRESC_W    = 2,
  parameter int unsigned WIN_CYCLES = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               special_mode,
  input  logic               wr_en,
  input  logic               wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [RATE_W-1:0]  rate_sel,
  output logic [PRESC_W-1:0] presc_sel,
  output logic               irq_flag
);
  import rti_pkg::*;

  localparam int unsigned RATE_LSB  = 0;
  localparam int unsigned PRESC_LSB = RATE_LSB + RATE_W;

  logic wr_ctrl;
  logic clr_req;
  logic tick;

  // Named decode events for the checks below.
  assign wr_ctrl = wr_en && (rti_reg_e'(wr_addr) == REG_CTRL);
  assign clr_req = wr_en && (rti_reg_e'(wr_addr) == REG_FLAG) && wr_data[0];

  rti_ctrl_reg #(
    .DATA_W    (DATA_W),
    .RATE_W    (RATE_W),
    .PRESC_W   (PRESC_W),
    .RATE_LSB  (RATE_LSB),
    .PRESC_LSB (PRESC_LSB),
    .WIN_CYCLES(WIN_CYCLES)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .special_mode(special_mode),
    .wr_ctrl     (wr_ctrl),
    .wdata       (wr_data),
    .rate        (rate_sel),
    .presc       (presc_sel)
  );

  rti_divider #(
    .DIV_W    (DIV_W),
    .RATE_BASE(RATE_BASE),
    .RATE_W   (RATE_W)
  ) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .rate (rate_sel),
    .tick (tick)
  );

  rti_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .clr_req(clr_req),
    .flag   (irq_flag)
  );

  // R4: the flag only rises on a divider tick.
  a_r4_rise_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_flag && !tick) |=> !irq_flag);

  // R10: a flag-register write never disturbs the control fields.
  a_r10_flag_write_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (rti_reg_e'(wr_addr) == REG_FLAG)) |=> ($stable(rate_sel) && $stable(presc_sel)));

endmodule

// File: tb/rti_gen_tb.sv
`timescale 1ns/1ps
module rti_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       special_mode = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] rate_sel;
  logic [1:0] presc_sel;
  logic       irq_flag;

  int unsigned cyc;
  int unsigned checks = 0;
  int unsigned failures = 0;

  always #10 clk = ~clk;

  // Edges counted since reset release.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  rti_gen u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .special_mode(special_mode),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rate_sel    (rate_sel),
    .presc_sel   (presc_sel),
    .irq_flag    (irq_flag)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at edge %0d", req, act, exp, cyc);
    end
  endtask

  task automatic do_reset(logic spec);
    @(negedge clk);
    rst_n = 1'b0;
    special_mode = spec;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_cyc(int unsigned n);
    while (cyc < n) @(negedge clk);
  endtask

  // Drive at a negedge; lands on the following posedge.
  task automatic do_write(logic addr, logic [7:0] data);
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  function automatic logic [7:0] ctrl_word(logic [1:0] presc, logic [1:0] rate);
    return {4'b0000, presc, rate};
  endfunction

  task automatic clear_flag(string req);
    do_write(1'b1, 8'h01);
    check(req, irq_flag, 1'b0);
  endtask

  // Flag must stay low until edge n and be high right after it.
  task automatic expect_tick(int unsigned n, string req);
    logic early = 1'b0;
    while (cyc < n) begin
      if (irq_flag) early = 1'b1;
      @(negedge clk);
    end
    check({req, " no early tick"}, early, 1'b0);
    check({req, " tick on time"}, irq_flag, 1'b1);
  endtask

  task automatic t_reset_state;
    do_reset(1'b0);
    check("R1 flag", irq_flag, 1'b0);
    check("R1 rate", rate_sel, 2'b00);
    check("R1 presc", presc_sel, 2'b00);
  endtask

  task automatic t_window_once;
    do_reset(1'b0);
    wait_cyc(5);
    do_write(1'b0, ctrl_word(2'b10, 2'b00));
    check("R7 first write", presc_sel, 2'b10);
    wait_cyc(10);
    do_write(1'b0, ctrl_word(2'b01, 2'b01));
    check("R8 second write ignored", presc_sel, 2'b10);
    check("R10 rate still loads", rate_sel, 2'b01);
    do_write(1'b0, ctrl_word(2'b00, 2'b11));
    check("R10 rate 11", rate_sel, 2'b11);
    check("R8 presc held", presc_sel, 2'b10);
  endtask

  task automatic t_window_edges;
    do_reset(1'b0);
    wait_cyc(64);
    do_write(1'b0, ctrl_word(2'b11, 2'b00));
    check("R8 write at edge 65 ignored", presc_sel, 2'b00);
    do_reset(1'b0);
    wait_cyc(63);
    do_write(1'b0, ctrl_word(2'b11, 2'b00));
    check("R7 write at edge 64 accepted", presc_sel, 2'b11);
  endtask

  task automatic t_special;
    do_reset(1'b1);
    wait_cyc(3);
    do_write(1'b0, ctrl_word(2'b01, 2'b00));
    check("R9 special write 1", presc_sel, 2'b01);
    wait_cyc(100);
    do_write(1'b0, ctrl_word(2'b10, 2'b00));
    check("R9 special write 2", presc_sel, 2'b10);
    wait_cyc(300);
    do_write(1'b0, ctrl_word(2'b11, 2'b10));
    check("R9 special write 3", presc_sel, 2'b11);
    check("R10 rate in special", rate_sel, 2'b10);
    special_mode = 1'b0;
    wait_cyc(310);
    do_write(1'b0, ctrl_word(2'b00, 2'b00));
    check("R8 normal after window", presc_sel, 2'b11);
  endtask

  task automatic t_ticks;
    do_reset(1'b0);
    wait_cyc(20);
    do_write(1'b0, ctrl_word(2'b00, 2'b00));
    expect_tick(8192, "R2");
    wait_cyc(8300);
    check("R4 flag sticky", irq_flag, 1'b1);
    do_write(1'b1, 8'h00);
    check("R4 zero write no effect", irq_flag, 1'b1);
    clear_flag("R4 clear");
    do_write(1'b0, ctrl_word(2'b00, 2'b01));
    expect_tick(16384, "R3 rate 01");
    clear_flag("R4 clear");
    do_write(1'b0, ctrl_word(2'b00, 2'b10));
    expect_tick(32768, "R3 rate 10");
    clear_flag("R4 clear");
    wait_cyc(33000);
    do_write(1'b0, ctrl_word(2'b00, 2'b00));
    expect_tick(40960, "R6 mid-period switch");
    clear_flag("R4 clear");
    do_write(1'b0, ctrl_word(2'b00, 2'b11));
    expect_tick(65536, "R3 rate 11");
    clear_flag("R4 clear");
    do_write(1'b0, ctrl_word(2'b00, 2'b00));
    wait_cyc(73727);
    do_write(1'b1, 8'h01);
    check("R5 tick beats clear", irq_flag, 1'b1);
    clear_flag("R5 later clear");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset_state();
    t_window_once();
    t_window_edges();
    t_special();
    t_ticks();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule